// File: doc/BRIEF.md
# Vector Memory Runahead Prefetcher

This block runs ahead of a vector memory unit. A scalar core pushes commands into a prefetch command queue, and the block takes them one at a time. It discards everything that is not a vector load or store. For a memory command it walks the addresses the command will touch and turns them into prefetch-only requests to a shared L2 cache. Each request carries a line-aligned address. No data comes back. The cache answers each request with a one-cycle acknowledgement, and that acknowledgement frees the request's slot.

The block must stay ahead of the memory unit, but not too far ahead. It keeps a signed lead count for this. The count rises for every memory command the block consumes or skips, and falls for every retire pulse from the memory unit.

- **Cold start or falling behind:** after reset, and whenever the lead is too small when a command arrives, the block skips a fixed number of commands without prefetching them. This lets it get ahead again.
- **Too far ahead:** when the lead reaches an upper threshold, the block stops taking commands.
- **Cache bandwidth:** the prefetches in flight are capped at one third of the cache's outstanding-miss capacity.

Top module: `vmem_runahead_pf`

## Requirements
- R1: After synchronous reset `rst`, `req_valid` is 0 and `cmd_ready` is 1. The lead and the in-flight count are zero, and a cold-start skip of SKIP_N commands is pending.
- R2: A command accepted with `cmd_is_mem`=0 is discarded. It issues no prefetch and leaves the lead unchanged.
- R3: The first SKIP_N memory commands accepted after reset are skipped. They issue no prefetch, and each one raises the lead by one.
- R4: Suppose a memory command is accepted with no skip pending and a lead below LO_LEAD. Then that command and the next SKIP_N-1 memory commands are skipped.
- R5: `cmd_ready` is 0 while an address walk is in progress or while the lead is at least HI_LEAD.
- R6: Requests handshaken but not yet acknowledged never exceed floor(MISS_CAP/3). While that many are in flight, `req_valid` is 0.
- R7: Each `ack` pulse frees one slot. An `ack` that arrives with nothing in flight has no effect.
- R8: A stride equal to ELEM_BYTES is unit stride. The line of an address is the address with its low log2(LINE_BYTES) bits cleared. A unit-stride command issues one request for each line, in ascending order, from the line of `base` to the line of `base+(count-1)*ELEM_BYTES`. These requests go out in consecutive cycles while `req_ready` is high and slots are free.
- R9: For any other stride, element i sits at `base+i*stride`, unsigned and modulo 2^ADDR_W. A request is issued for element 0. After that, a request is issued for each element whose line differs from the line of the element before it.
- R10: A memory command with `cmd_count`=0 issues no prefetch. It still raises the lead, and it still uses up a pending skip.
- R11: Once `req_valid` is high, it stays high with a stable `req_addr` until the cycle `req_ready` is high.
- R12: Each `retire` pulse lowers the lead by one. A memory-command accept and a retire in the same cycle leave the lead unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command queue has a command |
| cmd_ready | output | 1 | Block takes the command this cycle |
| cmd_is_mem | input | 1 | 1 for a vector load or store |
| cmd_base | input | ADDR_W | Byte address of element 0 |
| cmd_stride | input | STRIDE_W | Byte distance between elements (unsigned) |
| cmd_count | input | CNT_W | Number of elements |
| retire | input | 1 | Memory unit finished one memory command |
| req_valid | output | 1 | Prefetch request pending |
| req_ready | input | 1 | Cache takes the request |
| req_addr | output | ADDR_W | Line-aligned prefetch address |
| ack | input | 1 | Cache completed one prefetch |

## Verification
The assertions check the following on every cycle:
- the in-flight cap, counted from the request handshakes and the acknowledgements;
- that `req_valid` and `req_addr` hold until the handshake;
- that `cmd_ready` stays low once a lead count, rebuilt from accepts and retires, reaches HI_LEAD;
- that no request appears during the cold-start skip;
- that a discarded command or an empty command starts no walk.

Only the bench scenarios can show the exact line sequence for each stride, count and alignment, and the reskip after the memory unit catches up. They also show the one-line-per-cycle rate for unit stride, that a spurious acknowledgement is ignored, and that withheld acknowledgements stall the walk at the cap.

// File: rtl/vmem_runahead_pf.sv
`timescale 1ns/1ps
module vmem_runahead_pf #(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int CNT_W      = 8,
  parameter int LINE_BYTES = 64,
  parameter int ELEM_BYTES = 8,
  parameter int MISS_CAP   = 12,
  parameter int LO_LEAD    = 2,
  parameter int HI_LEAD    = 6,
  parameter int SKIP_N     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_is_mem,
  input  logic [ADDR_W-1:0]   cmd_base,
  input  logic [STRIDE_W-1:0] cmd_stride,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic                retire,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  input  logic                ack
);

  localparam int OFS_W    = $clog2(LINE_BYTES);
  localparam int ELEM_SH  = $clog2(ELEM_BYTES);
  localparam int MAX_INFL = MISS_CAP / 3;
  localparam int INFL_W   = $clog2(MAX_INFL + 1);
  localparam int LEAD_W   = $clog2(HI_LEAD + 1) + 2;
  localparam int SKIP_W   = $clog2(SKIP_N + 1);
  localparam logic signed [LEAD_W-1:0] LO_S  = LEAD_W'(LO_LEAD);
  localparam logic signed [LEAD_W-1:0] HI_S  = LEAD_W'(HI_LEAD);
  localparam logic signed [LEAD_W-1:0] MIN_S = {1'b1, {(LEAD_W-1){1'b0}}};

  logic signed [LEAD_W-1:0] lead;
  logic [SKIP_W-1:0]        skip_left;
  logic [INFL_W-1:0]        infl;
  logic                     busy, unit, first;
  logic [ADDR_W-1:0]        cur, last_line, end_line, stride_q;
  logic [CNT_W-1:0]         rem;

  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  endfunction

  logic accept, mem_acc, skip_now, walk_start, need, fire, step_el, ack_ok;
  logic [ADDR_W-1:0] cur_line, last_elem;

  assign cmd_ready  = !busy && (lead < HI_S);
  assign accept     = cmd_valid && cmd_ready;
  assign mem_acc    = accept && cmd_is_mem;
  assign skip_now   = (skip_left != '0) || (lead < LO_S);
  assign walk_start = mem_acc && !skip_now && (cmd_count != '0);
  assign last_elem  = cmd_base + ((ADDR_W'(cmd_count) - ADDR_W'(1)) << ELEM_SH);

  assign cur_line   = line_of(cur);
  assign need       = unit || first || (cur_line != last_line);
  assign req_valid  = busy && need && (infl < INFL_W'(MAX_INFL));
  assign req_addr   = cur_line;
  assign fire       = req_valid && req_ready;
  assign step_el    = busy && !unit && (fire || !need);
  assign ack_ok     = ack && (infl != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lead <= '0;
    end else if (mem_acc && !retire) begin
      lead <= lead + LEAD_W'(1);
    end else if (retire && !mem_acc && lead != MIN_S) begin
      lead <= lead - LEAD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_left <= SKIP_W'(SKIP_N);
    end else if (mem_acc && skip_now) begin
      skip_left <= (skip_left != '0) ? skip_left - SKIP_W'(1) : SKIP_W'(SKIP_N - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      infl <= '0;
    end else if (fire && !ack_ok) begin
      infl <= infl + INFL_W'(1);
    end else if (ack_ok && !fire) begin
      infl <= infl - INFL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      unit      <= 1'b0;
      first     <= 1'b0;
      cur       <= '0;
      last_line <= '0;
      end_line  <= '0;
      stride_q  <= '0;
      rem       <= '0;
    end else if (walk_start) begin
      busy     <= 1'b1;
      unit     <= (cmd_stride == STRIDE_W'(ELEM_BYTES));
      first    <= 1'b1;
      cur      <= (cmd_stride == STRIDE_W'(ELEM_BYTES)) ? line_of(cmd_base) : cmd_base;
      end_line <= line_of(last_elem);
      stride_q <= ADDR_W'(cmd_stride);
      rem      <= cmd_count;
    end else if (busy && unit) begin
      if (fire) begin
        if (cur == end_line) busy <= 1'b0;
        else                 cur  <= cur + ADDR_W'(LINE_BYTES);
      end
    end else if (step_el) begin
      if (fire) begin
        last_line <= cur_line;
        first     <= 1'b0;
      end
      if (rem == CNT_W'(1)) begin
        busy <= 1'b0;
      end else begin
        rem <= rem - CNT_W'(1);
        cur <= cur + stride_q;
      end
    end
  end

endmodule

module vmem_runahead_pf_chk #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 8,
  parameter int MISS_CAP = 12,
  parameter int HI_LEAD  = 6,
  parameter int SKIP_N   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_is_mem,
  input logic [CNT_W-1:0]  cmd_count,
  input logic              retire,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              ack
);
  int outst_c, lead_c, macc_c;
  logic mem_take;
  assign mem_take = cmd_valid && cmd_ready && cmd_is_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst_c <= 0;
      lead_c  <= 0;
      macc_c  <= 0;
    end else begin
      outst_c <= outst_c + ((req_valid && req_ready) ? 1 : 0) - ((ack && outst_c > 0) ? 1 : 0);
      lead_c  <= lead_c + (mem_take ? 1 : 0) - (retire ? 1 : 0);
      if (mem_take && macc_c <= SKIP_N) macc_c <= macc_c + 1;
    end
  end

  // R6
  infl_cap_chk: assert property (@(posedge clk) disable iff (rst) outst_c <= MISS_CAP / 3);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R5
  lead_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (lead_c >= HI_LEAD) |-> !cmd_ready);

  // R3
  cold_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (macc_c <= SKIP_N) |-> !req_valid);

  // R2
  nonmem_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !cmd_is_mem && !req_valid) |=> !req_valid);

  // R10
  empty_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_count == '0 && !req_valid) |=> !req_valid);
endmodule

bind vmem_runahead_pf vmem_runahead_pf_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MISS_CAP(MISS_CAP), .HI_LEAD(HI_LEAD), .SKIP_N(SKIP_N)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_is_mem(cmd_is_mem), .cmd_count(cmd_count), .retire(retire),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .ack(ack)
);

// File: tb/sim_vmem_runahead_pf.sv
`timescale 1ns/1ps
module sim_vmem_runahead_pf;
  localparam int LINE = 16, ELEM = 4, CAP = 12, MAXI = CAP / 3, LO = 2, HI = 6, SKIP = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, cmd_valid = 1'b0, cmd_ready, cmd_is_mem = 1'b0, retire = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_stride = '0;
  logic [7:0]  cmd_count = '0;
  logic req_valid, req_ready = 1'b0, ack = 1'b0;
  logic [31:0] req_addr;

  vmem_runahead_pf #(.ADDR_W(32), .STRIDE_W(16), .CNT_W(8), .LINE_BYTES(LINE),
    .ELEM_BYTES(ELEM), .MISS_CAP(CAP), .LO_LEAD(LO), .HI_LEAD(HI), .SKIP_N(SKIP)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_mem(cmd_is_mem), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
    .cmd_count(cmd_count), .retire(retire), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .ack(ack));

  int tests = 0, fails = 0;
  int lead_m = 0, skip_m = SKIP, outst = 0, hs_total = 0, cyc = 0;
  int first_hs = -1, last_hs = -1;
  int rdy_pct = 100, ack_pct = 100;
  bit auto_ack = 1'b1, force_ack = 1'b0, last_acc = 1'b0;
  bit pv = 1'b0, prdy = 1'b0;
  logic [31:0] paddr = '0;
  logic [31:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_lines(input logic [31:0] b, input logic [15:0] s, input int n);
    logic [31:0] prev = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] l;
      l = (b + 32'(i) * 32'(s)) & ~32'(LINE - 1);
      if (i == 0 || l != prev) exp_q.push_back(l);
      prev = l;
    end
  endtask

  task automatic step();
    ack = force_ack || (auto_ack && outst > 0 && ($urandom % 100) < ack_pct);
    req_ready = ($urandom % 100) < rdy_pct;
    #1;
    last_acc = 1'b0;
    if (!rst) begin
      if (cmd_valid && lead_m >= HI) chk(!cmd_ready, "R5", "cmd_ready at high lead", cmd_ready, 0);
      if (pv && !prdy) chk(req_valid && req_addr == paddr, "R11", "request held", req_addr, paddr);
      if (outst >= MAXI) chk(!req_valid, "R6", "req_valid at cap", req_valid, 0);
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected request", req_addr, -1);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(req_addr == e, "R8/R9", "request address", req_addr, e);
        end
        outst++;
        hs_total++;
        if (first_hs < 0) first_hs = cyc;
        last_hs = cyc;
      end
      if (ack && outst > 0) outst--;
      if (cmd_valid && cmd_ready) begin
        last_acc = 1'b1;
        if (cmd_is_mem) begin
          bit sk;
          sk = (skip_m > 0) || (lead_m < LO);
          lead_m++;
          if (sk) skip_m = (skip_m > 0) ? skip_m - 1 : SKIP - 1;
          else push_lines(cmd_base, cmd_stride, int'(cmd_count));
        end
      end
      if (retire) lead_m--;
      pv = req_valid;
      prdy = req_ready;
      paddr = req_addr;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic send(input bit m, input logic [31:0] b, input logic [15:0] s, input int n);
    cmd_valid = 1'b1; cmd_is_mem = m; cmd_base = b; cmd_stride = s; cmd_count = 8'(n);
    do step(); while (!last_acc);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_retire();
    retire = 1'b1; step(); retire = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || (auto_ack && outst != 0)) step();
    repeat (12) step();
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hs0, n;
    bit seen;
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(!req_valid, "R1", "req_valid after reset", req_valid, 0);
    chk(cmd_ready, "R1", "cmd_ready after reset", cmd_ready, 1);
    @(negedge clk);

    // R3 cold-start skip
    hs0 = hs_total;
    for (int i = 0; i < SKIP; i++) send(1'b1, 32'h40 * i, 16'(ELEM), 4);
    repeat (10) step();
    chk(hs_total == hs0, "R3", "requests during cold skip", hs_total - hs0, 0);

    // R2 non-memory command dropped
    send(1'b0, 32'h500, 16'(ELEM), 8);
    repeat (10) step();
    chk(hs_total == hs0, "R2", "requests after non-mem command", hs_total - hs0, 0);
    send(1'b1, 32'h100, 16'(ELEM), 8);
    drain();
    chk(hs_total - hs0 == 2, "R2", "first walked command lines", hs_total - hs0, 2);

    // R10 empty command counts into lead
    hs0 = hs_total;
    send(1'b1, 32'h700, 16'(ELEM), 0);
    repeat (6) step();
    chk(hs_total == hs0, "R10", "requests for empty command", hs_total - hs0, 0);
    send(1'b1, 32'h180, 16'(8), 3);
    drain();

    // R5 stall at high lead, R12 retire releases it
    cmd_valid = 1'b1; cmd_is_mem = 1'b1; cmd_base = 32'h300; cmd_stride = 16'(ELEM); cmd_count = 8'd4;
    seen = 1'b0;
    repeat (8) begin step(); seen |= last_acc; end
    chk(!seen, "R5", "command taken at high lead", seen, 0);
    retire = 1'b1; step(); retire = 1'b0;
    seen = last_acc;
    while (!last_acc) step();
    cmd_valid = 1'b0;
    chk(!seen, "R12", "accepted before retire took effect", seen, 0);
    drain();

    // R4 reskip when memory unit catches up
    while (lead_m > 1) pulse_retire();
    hs0 = hs_total;
    for (int i = 0; i < SKIP; i++) send(1'b1, 32'h800 + 32'h40 * i, 16'(ELEM), 4);
    repeat (10) step();
    chk(hs_total == hs0, "R4", "requests during reskip", hs_total - hs0, 0);
    send(1'b1, 32'h900, 16'(ELEM), 4);
    drain();
    chk(hs_total - hs0 == 1, "R4", "walk resumes after reskip", hs_total - hs0, 1);

    // R8 unit stride back to back
    while (lead_m > 3) pulse_retire();
    first_hs = -1;
    send(1'b1, 32'h203, 16'(ELEM), 16);
    drain();
    chk(last_hs - first_hs == 3, "R8", "cycles across four lines", last_hs - first_hs, 3);

    // R7 spurious acks ignored, then cap reached with acks held
    force_ack = 1'b1; repeat (3) step(); force_ack = 1'b0;
    while (lead_m > 3) pulse_retire();
    auto_ack = 1'b0;
    send(1'b1, 32'h1000, 16'(ELEM), 40);
    repeat (20) step();
    chk(outst == MAXI, "R6", "in flight at stall", outst, MAXI);
    chk(!req_valid, "R6", "req_valid with acks held", req_valid, 0);
    chk(exp_q.size() == 10 - MAXI, "R7", "lines waiting", exp_q.size(), 10 - MAXI);
    auto_ack = 1'b1;
    drain();
    chk(exp_q.size() == 0, "R7", "lines after acks", exp_q.size(), 0);

    // R9 sweep of strides, counts and alignments
    rdy_pct = 70; ack_pct = 50; n = 0;
    foreach (exp_q[k]) exp_q.delete(k);
    for (int si = 0; si < 9; si++) begin
      for (int c = 0; c < 6; c++) begin
        for (int oi = 0; oi < 3; oi++) begin
          logic [15:0] strides [9];
          strides = '{16'd0, 16'd4, 16'd8, 16'd12, 16'd16, 16'd20, 16'd36, 16'd48, 16'd5};
          n++;
          if (n % 17 == 0) while (lead_m > 0) pulse_retire();
          else while (lead_m > 3) pulse_retire();
          send(1'b1, 32'h4000 + 32'h100 * n + 32'(oi * 7), strides[si], c);
        end
      end
    end
    drain();
    chk(exp_q.size() == 0, "R9", "lines left after sweep", exp_q.size(), 0);
    chk(outst == 0, "R7", "in flight after sweep", outst, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule